// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bit-level core of a single-master I2C controller. It drives the two open-drain lines through output enables: an enable of 1 pulls the line low, and an enable of 0 releases it to the pull-up. It reads both lines back through a synchronizer. The block runs one command at a time. A command is a start (which is also used for a repeated start), a stop, a byte write or a byte read. Each command is handed over with a valid/ready handshake, and the block answers with a one-cycle done pulse.

A byte write returns the target's acknowledge bit. A byte read returns the received byte, and a flag given with the command chooses whether the ninth clock carries ACK or NACK. After every SCL release the engine waits for the line to read high before it starts timing the high phase, so a target that stretches the clock is honoured.

Every byte operation ends with SCL held low and SDA released. This lets the next byte or a repeated start follow straight away. All timing comes from counts of system clock cycles, set by parameters.

Top module: `i2c_byte_engine`

## Requirements
- R1: While reset is asserted and right after it, both line enables are 0, cmd_ready_o is 1 and done_o is 0.
- R2: A command is taken when cmd_valid_i and cmd_ready_o are both 1. The command codes on cmd_i are 0 for start, 1 for stop, 2 for write and 3 for read. cmd_ready_o is 0 from the cycle after acceptance until completion. done_o is a one-cycle pulse, and cmd_ready_o is 1 in that same cycle.
- R3: Start releases SDA, then releases SCL, waits for SCL to read high, and then pulls SDA low. It ends with SCL released and SDA pulled low. Issued while SCL is held low after a byte, it forms a repeated start.
- R4: Stop pulls SDA low, releases SCL, waits for SCL to read high, and then releases SDA. Afterwards both lines are released.
- R5: A write shifts out tx_byte_i most significant bit first. Outside start and stop, SDA changes only while SCL is low.
- R6: On the ninth clock of a write, SDA is released. ack_o becomes 1 if SDA reads low while SCL is high (ACK) and 0 if it reads high (NACK).
- R7: A read keeps SDA released for eight clocks and samples one bit, most significant first, each time SCL reads high. rx_byte_o holds the byte when done_o pulses.
- R8: On the ninth clock of a read, SDA is pulled low when ack_en_i was 1 at acceptance (ACK) and released when it was 0 (NACK).
- R9: When a write or read completes, SCL is held low (scl_oe_o=1) and SDA is released (sda_oe_o=0).
- R10: After each SCL release the engine stalls until SCL reads high. It then keeps SCL high for at least T_HIGH cycles.
- R11: Every SCL low period the engine drives lasts at least T_LOW cycles.
- R12: cmd_valid_i has no effect while a command is in progress. Such a request is neither accepted nor executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command can be taken |
| cmd_i | input | 2 | Command code: 0 start, 1 stop, 2 write, 3 read |
| tx_byte_i | input | 8 | Byte to write |
| ack_en_i | input | 1 | Read: 1 sends ACK, 0 sends NACK |
| rx_byte_o | output | 8 | Last byte read |
| ack_o | output | 1 | Last write: 1 when the target acknowledged |
| done_o | output | 1 | Command complete pulse |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The bench builds the engine with T_LOW=7, T_HIGH=4 and a two-stage synchronizer. With these values each byte takes about 150 cycles, so many transactions fit in a short run, including clock stretching of up to nine cycles. The odd T_LOW splits the low phase unevenly: three cycles before SDA changes and four after. This shows that the data-change point and the minimum low width are two separate properties. With a short high phase, the synchronizer delay is a large share of the phase, so the wait for SCL to read high decides the timing.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S_PREP,
    ST_S_RISE,
    ST_S_SETUP,
    ST_S_HOLD,
    ST_P_LOW,
    ST_P_RISE,
    ST_P_SETUP,
    ST_P_FREE,
    ST_B_LOW1,
    ST_B_LOW2,
    ST_B_RISE,
    ST_B_HIGH,
    ST_B_END
  } state_e;

endpackage

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= RST_VAL;
      else         stg_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_eng_timer.sv
module i2c_eng_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         msb_o,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= load_val_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign msb_o = sr_q[W-1];
  assign q_o   = sr_q;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int T_LOW       = 140,
  parameter int T_HIGH      = 110,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] cmd_i,
  input  logic [7:0] tx_byte_i,
  input  logic       ack_en_i,
  output logic [7:0] rx_byte_o,
  output logic       ack_o,
  output logic       done_o,
  output logic       scl_oe_o,
  input  logic       scl_i,
  output logic       sda_oe_o,
  input  logic       sda_i
);

  localparam int BYTE_W  = 8;
  localparam int BIT_W   = $clog2(BYTE_W + 1);
  localparam int T_SETUP = T_LOW / 2;
  localparam int T_HOLD  = T_LOW - T_SETUP;
  localparam int T_MAX   = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int CW      = $clog2(T_MAX + 1);

  localparam logic [CW-1:0]    LD_SETUP = CW'(T_SETUP);
  localparam logic [CW-1:0]    LD_HOLD  = CW'(T_HOLD);
  localparam logic [CW-1:0]    LD_HIGH  = CW'(T_HIGH);
  localparam logic [CW-1:0]    LD_LOW   = CW'(T_LOW);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  state_e            state_q, state_d;
  cmd_e              cmd_q, cmd_d;
  logic              acken_q, acken_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              scl_oe_q, scl_oe_d;
  logic              sda_oe_q, sda_oe_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              done_q, done_d;

  logic              tmr_load, tmr_zero;
  logic [CW-1:0]     tmr_val;
  logic              sh_load, sh_shift, sh_msb;
  logic [BYTE_W-1:0] sh_q;
  logic              scl_h, sda_h;

  i2c_eng_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_h, sda_h})
  );

  i2c_eng_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  i2c_eng_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (tx_byte_i),
    .shift_i    (sh_shift),
    .bit_i      (sda_h),
    .msb_o      (sh_msb),
    .q_o        (sh_q)
  );

  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    acken_d  = acken_q;
    bit_d    = bit_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    ack_d    = ack_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = LD_SETUP;
    sh_load  = 1'b0;
    sh_shift = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          cmd_d    = cmd_e'(cmd_i);
          acken_d  = ack_en_i;
          bit_d    = '0;
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          unique case (cmd_e'(cmd_i))
            CMD_START: begin sda_oe_d = 1'b0; state_d = ST_S_PREP; end
            CMD_STOP:  begin sda_oe_d = 1'b1; state_d = ST_P_LOW;  end
            default:   begin scl_oe_d = 1'b1; state_d = ST_B_LOW1; end
          endcase
        end
      end
      // start / repeated start
      ST_S_PREP: if (tmr_zero) begin scl_oe_d = 1'b0; state_d = ST_S_RISE; end
      ST_S_RISE: if (scl_h) begin
        tmr_load = 1'b1; tmr_val = LD_HIGH; state_d = ST_S_SETUP;
      end
      ST_S_SETUP: if (tmr_zero) begin
        sda_oe_d = 1'b1; tmr_load = 1'b1; tmr_val = LD_HIGH; state_d = ST_S_HOLD;
      end
      ST_S_HOLD: if (tmr_zero) begin done_d = 1'b1; state_d = ST_IDLE; end
      // stop
      ST_P_LOW: if (tmr_zero) begin scl_oe_d = 1'b0; state_d = ST_P_RISE; end
      ST_P_RISE: if (scl_h) begin
        tmr_load = 1'b1; tmr_val = LD_HIGH; state_d = ST_P_SETUP;
      end
      ST_P_SETUP: if (tmr_zero) begin
        sda_oe_d = 1'b0; tmr_load = 1'b1; tmr_val = LD_LOW; state_d = ST_P_FREE;
      end
      ST_P_FREE: if (tmr_zero) begin done_d = 1'b1; state_d = ST_IDLE; end
      // byte: bits 0..7 data, bit 8 acknowledge
      ST_B_LOW1: if (tmr_zero) begin
        if (bit_q == LAST_BIT) sda_oe_d = (cmd_q == CMD_READ) ? acken_q : 1'b0;
        else                   sda_oe_d = (cmd_q == CMD_WRITE) ? ~sh_msb : 1'b0;
        tmr_load = 1'b1; tmr_val = LD_HOLD; state_d = ST_B_LOW2;
      end
      ST_B_LOW2: if (tmr_zero) begin scl_oe_d = 1'b0; state_d = ST_B_RISE; end
      ST_B_RISE: if (scl_h) begin
        if (bit_q == LAST_BIT) begin
          if (cmd_q == CMD_WRITE) ack_d = ~sda_h;
        end else begin
          sh_shift = 1'b1;
        end
        tmr_load = 1'b1; tmr_val = LD_HIGH; state_d = ST_B_HIGH;
      end
      ST_B_HIGH: if (tmr_zero) begin
        scl_oe_d = 1'b1;
        tmr_load = 1'b1;
        if (bit_q == LAST_BIT) begin
          state_d = ST_B_END;
        end else begin
          bit_d   = bit_q + 1'b1;
          state_d = ST_B_LOW1;
        end
      end
      ST_B_END: if (tmr_zero) begin
        sda_oe_d = 1'b0;
        if (cmd_q == CMD_READ) rx_d = sh_q;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_START;
      acken_q  <= 1'b0;
      bit_q    <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      ack_q    <= 1'b0;
      rx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      acken_q  <= acken_d;
      bit_q    <= bit_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
      ack_q    <= ack_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign scl_oe_o    = scl_oe_q;
  assign sda_oe_o    = sda_oe_q;
  assign ack_o       = ack_q;
  assign rx_byte_o   = rx_q;
  assign done_o      = done_q;

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
  import i2c_eng_pkg::*;
#(
  parameter int T_LOW = 140
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic done_o,
  input logic scl_oe_o,
  input logic scl_i,
  input logic sda_oe_o,
  input cmd_e cmd_q
);

  localparam int LCW = $clog2(T_LOW + 2);
  localparam logic [LCW-1:0] SAT = LCW'(T_LOW + 1);
  localparam logic [LCW-1:0] MIN = LCW'(T_LOW);

  logic [LCW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_cnt <= '0;
    else if (!scl_oe_o)     low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  a_r2_done_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r5_sda_quiet_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && scl_i && $past(scl_i)) |-> (cmd_q == CMD_START || cmd_q == CMD_STOP));

  a_r9_byte_end_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (cmd_q == CMD_WRITE || cmd_q == CMD_READ)) |-> (scl_oe_o && !sda_oe_o));

  a_r10_stall_while_stretched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !scl_i) |=> (!scl_oe_o && $stable(sda_oe_o)));

  a_r11_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> (low_cnt >= MIN));

endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.T_LOW(T_LOW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .done_o      (done_o),
  .scl_oe_o    (scl_oe_o),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .cmd_q       (cmd_q)
);

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
  import i2c_eng_pkg::*;

  localparam int T_LOW  = 7;
  localparam int T_HIGH = 4;
  localparam int SYNC   = 2;

  typedef struct packed {
    logic       rd;
    logic [7:0] data;
    logic       slv_ack;
    logic       ack_en;
    logic [3:0] stretch;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'hA5, 1'b1, 1'b0, 4'd0},
    '{1'b0, 8'h3C, 1'b0, 1'b0, 4'd0},
    '{1'b1, 8'h96, 1'b0, 1'b0, 4'd0},
    '{1'b1, 8'h5A, 1'b0, 1'b1, 4'd0},
    '{1'b0, 8'hFF, 1'b1, 1'b0, 4'd9},
    '{1'b1, 8'h01, 1'b0, 1'b1, 4'd6}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [7:0] tx = 8'h00;
  logic       ack_en = 1'b0;
  logic       cmd_ready, ack, done, m_scl, m_sda;
  logic [7:0] rx;
  logic       s_scl = 1'b0;
  logic       s_sda = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = ~(m_scl | s_scl);
  assign sda_bus = ~(m_sda | s_sda);

  always #2 clk = ~clk;

  i2c_byte_engine #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .SYNC_STAGES(SYNC)) i_i2c_byte_engine (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_i       (cmd),
    .tx_byte_i   (tx),
    .ack_en_i    (ack_en),
    .rx_byte_o   (rx),
    .ack_o       (ack),
    .done_o      (done),
    .scl_oe_o    (m_scl),
    .scl_i       (scl_bus),
    .sda_oe_o    (m_sda),
    .sda_i       (sda_bus)
  );

  // target model and bus monitor
  int       n_tests = 0;
  int       n_fail  = 0;
  int       bit_idx = 0;
  int       stretch_n = 0;
  int       str_cnt = 0;
  int       start_cnt = 0;
  int       stop_cnt = 0;
  int       sda_viol = 0;
  int       lo_run = 0;
  int       hi_run = 0;
  int       min_lo = 1000000;
  int       min_hi = 1000000;
  int       rd_ptr = 0;
  bit       rd_armed = 1'b0;
  bit       ack_drive = 1'b0;
  bit       in_byte = 1'b0;
  bit [7:0] rd_buf [2];
  bit [7:0] obs_byte = 8'h00;
  bit       obs_ack9 = 1'b1;
  bit       prev_scl = 1'b1;
  bit       prev_sda = 1'b1;
  bit       prev_m_scl = 1'b0;
  bit       cur_scl, cur_sda;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_m_scl && !m_scl && stretch_n > 0) begin
        s_scl = 1'b1; str_cnt = stretch_n;
      end else if (str_cnt > 0) begin
        str_cnt = str_cnt - 1;
        if (str_cnt == 0) s_scl = 1'b0;
      end
      prev_m_scl = m_scl;
      cur_scl = ~(m_scl | s_scl);
      cur_sda = ~(m_sda | s_sda);
      if (cur_scl && prev_scl && prev_sda && !cur_sda) begin start_cnt++; bit_idx = 0; end
      if (cur_scl && prev_scl && !prev_sda && cur_sda) begin stop_cnt++; bit_idx = 0; rd_armed = 1'b0; end
      if (cur_scl && prev_scl && (cur_sda != prev_sda) && in_byte) sda_viol++;
      if (cur_scl) hi_run++; else lo_run++;
      if (!prev_scl && cur_scl) begin
        if (lo_run > 0 && lo_run < min_lo) min_lo = lo_run;
        lo_run = 0;
        if (bit_idx < 8) obs_byte = {obs_byte[6:0], cur_sda};
        else begin
          obs_ack9 = cur_sda;
          if (rd_armed) begin
            if (cur_sda) rd_armed = 1'b0;
            else rd_ptr = rd_ptr + 1;
          end
        end
        bit_idx++;
      end
      if (prev_scl && !cur_scl) begin
        if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
      if (!cur_scl) begin
        if (bit_idx == 9) bit_idx = 0;
        if (rd_armed && bit_idx < 8) s_sda = ~rd_buf[rd_ptr[0]][7-bit_idx];
        else s_sda = (!rd_armed && bit_idx == 8 && ack_drive);
      end
      prev_scl = cur_scl;
      prev_sda = ~(m_sda | s_sda);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] b, input logic ae);
    int t = 0;
    @(negedge clk);
    while (!cmd_ready && t < 5000) begin @(negedge clk); t++; end
    cmd_valid = 1'b1; cmd = c; tx = b; ack_en = ae;
    in_byte = (c == CMD_WRITE || c == CMD_READ);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 ready low after accept", cmd_ready, 0);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done == 1'b1, "R2 done pulse seen", done, 1);
    check(cmd_ready == 1'b1, "R2 ready with done", cmd_ready, 1);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", done, 0);
    in_byte = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] c, input logic [7:0] b, input logic ae);
    issue(c, b, ae);
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s0;
    int p0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(m_scl == 1'b0 && m_sda == 1'b0, "R1 lines released in reset", {m_scl, m_sda}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    check(done == 1'b0, "R1 done low after reset", done, 0);
    check(m_scl == 1'b0 && m_sda == 1'b0, "R1 lines released after reset", {m_scl, m_sda}, 0);

    for (int v = 0; v < NVEC; v++) begin
      stretch_n = int'(VECS[v].stretch);
      ack_drive = VECS[v].slv_ack;
      s0 = start_cnt; p0 = stop_cnt;
      do_cmd(CMD_START, 8'h00, 1'b0);
      check(start_cnt == s0 + 1, "R3 start seen on bus", start_cnt, s0 + 1);
      check(m_scl == 1'b0 && m_sda == 1'b1, "R3 SCL released SDA low", {m_scl, m_sda}, 1);
      if (!VECS[v].rd) begin
        do_cmd(CMD_WRITE, VECS[v].data, 1'b0);
        check(obs_byte == VECS[v].data, "R5 write byte msb first", obs_byte, VECS[v].data);
        check(ack == VECS[v].slv_ack, "R6 ack sampled", ack, VECS[v].slv_ack);
        check(obs_ack9 == !VECS[v].slv_ack, "R6 SDA released on ninth", obs_ack9, !VECS[v].slv_ack);
      end else begin
        rd_buf[0] = VECS[v].data; rd_buf[1] = ~VECS[v].data; rd_ptr = 0; rd_armed = 1'b1;
        do_cmd(CMD_READ, 8'h00, VECS[v].ack_en);
        check(rx == VECS[v].data, "R7 read byte", rx, VECS[v].data);
        check(obs_ack9 == !VECS[v].ack_en, "R8 ninth bit", obs_ack9, !VECS[v].ack_en);
        if (VECS[v].ack_en) begin
          do_cmd(CMD_READ, 8'h00, 1'b0);
          check(rx == ~VECS[v].data, "R7 second read byte", rx, ~VECS[v].data);
          check(obs_ack9 == 1'b1, "R8 nack on last", obs_ack9, 1);
        end
      end
      check(m_scl == 1'b1 && m_sda == 1'b0, "R9 SCL held low SDA released", {m_scl, m_sda}, 2);
      do_cmd(CMD_STOP, 8'h00, 1'b0);
      check(stop_cnt == p0 + 1, "R4 stop seen on bus", stop_cnt, p0 + 1);
      check(scl_bus && sda_bus && !m_scl && !m_sda, "R4 bus idle", {scl_bus, sda_bus}, 3);
    end
    stretch_n = 0;

    // R12: requests while busy are ignored
    ack_drive = 1'b1;
    do_cmd(CMD_START, 8'h00, 1'b0);
    p0 = stop_cnt;
    issue(CMD_WRITE, 8'hC3, 1'b0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd = CMD_STOP;
      if (k == 10) check(cmd_ready == 1'b0, "R12 not ready while busy", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    wait_done();
    check(stop_cnt == p0, "R12 no stop executed", stop_cnt, p0);
    check(obs_byte == 8'hC3, "R12 write unaffected", obs_byte, 8'hC3);
    check(m_scl == 1'b1, "R12 SCL still held low", m_scl, 1);

    // R3 repeated start from SCL low, then read with NACK
    s0 = start_cnt;
    do_cmd(CMD_START, 8'h00, 1'b0);
    check(start_cnt == s0 + 1, "R3 repeated start", start_cnt, s0 + 1);
    rd_buf[0] = 8'h6E; rd_ptr = 0; rd_armed = 1'b1;
    do_cmd(CMD_READ, 8'h00, 1'b0);
    check(rx == 8'h6E, "R7 read after repeated start", rx, 8'h6E);
    check(obs_ack9 == 1'b1, "R8 nack released", obs_ack9, 1);
    do_cmd(CMD_STOP, 8'h00, 1'b0);
    check(scl_bus && sda_bus, "R4 bus idle after repeated start", {scl_bus, sda_bus}, 3);

    check(sda_viol == 0, "R5 SDA stable while SCL high", sda_viol, 0);
    check(min_lo >= T_LOW, "R11 SCL low width", min_lo, T_LOW);
    check(min_hi >= T_HIGH, "R10 SCL high width after stretch", min_hi, T_HIGH);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule